// File: doc/BRIEF.md
# Daisy-Chained Threshold DAC Loader

This block sets the discriminator thresholds of a front-end carrier board. The board holds eight serial DAC devices wired in series on one SPI link: the data output of each device feeds the data input of the next, and the output of the last device returns to the controller. Each device has eight 12-bit channels, so the board has 64 threshold codes. A host fills a 64-entry code store through a write-only register port and then pulses a start input.

One load runs eight update passes, one per channel address, and then one no-op pass. In every pass chip-select stays low for 192 serial clocks and carries one 24-bit frame for each device, starting with the device farthest from the controller. Chip-select rises after the last bit, so all devices latch together. The bits that come back during a pass must match the frames sent in the previous pass. A mismatch sets a sticky flag and records the pass that was corrupted, and the whole load is retried. When the retry budget is used up, the block raises its final error.

Top module: `thrDacLoader`

## Requirements
- R1: A host write with `regWrEn` high while `busy` is low stores `regWrData` in the code entry for device `regAddr[5:3]` (device 0 is nearest the controller) and channel `regAddr[2:0]`. A load started in the same cycle as the write uses the new code.
- R2: Each device frame is 24 bits, sent MSB first. Bits [23:20] hold the command (4'b0011 = write and update), bits [19:16] the channel, bits [15:4] the code and bits [3:0] zero.
- R3: In every pass the frame for device 7 (farthest) is shifted first and the frame for device 0 last. `csN` stays low for exactly 192 rising edges of `sclk`.
- R4: A load is nine chip-select windows: channels 0 to 7 in order, then one no-op pass whose frames are 4'b1111 followed by 20 zero bits. After a clean load, every device channel holds its stored code.
- R5: `sclk` idles low and has a period of CLK_DIV system clocks. `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge.
- R6: The bits returned during pass N are compared with the frames sent in pass N-1. The bits returned during pass 0 are ignored.
- R7: On a mismatch, `mismatch` is set and stays set, `failPass` is set to N-1, and the load restarts from pass 0.
- R8: A load ends with `done` when it succeeds, or with `error` once MAX_RETRY retries have also failed. `done`, `error` and `mismatch` are cleared when a start is accepted. `done` and `error` are never high together.
- R9: While `busy` is high, host writes and start requests are ignored.
- R10: After reset, `csN` is 1, `sclk` is 0, and `busy`, `done`, `error` and `mismatch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe |
| regAddr | input | 6 | Code entry index {device, channel} |
| regWrData | input | 12 | Threshold code to store |
| start | input | 1 | Start-load request |
| busy | output | 1 | A load is in progress |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Shared chip-select, active low |
| mosi | output | 1 | Serial data to the near end of the chain |
| miso | input | 1 | Serial data back from the far end of the chain |
| done | output | 1 | Last load succeeded |
| error | output | 1 | Last load failed after all retries |
| mismatch | output | 1 | Sticky flag: a loopback mismatch was seen |
| failPass | output | 4 | Index of the last pass found corrupted |

## Verification
Two things can happen in the same clock cycle: a host write into the code store and the start of a load. The bench raises `regWrEn` and `start` on the same edge while the block is idle. It then checks, through a behavioural model of the DAC chain, that the first pass already carries the new code. A second collision, a write or start arriving while a load is running, is provoked in the middle of a pass. The bench judges it by the chip-select window count and by reloading the board afterwards.

// File: rtl/thrDacPkg.sv
package thrDacPkg;
  localparam int FRAME_W = 24;
  localparam int CMD_W   = 4;
  localparam int ADDR_W  = 4;
  localparam logic [CMD_W-1:0] CMD_WRUPD = 4'b0011;
  localparam logic [CMD_W-1:0] CMD_NOP   = 4'b1111;

  typedef struct packed {
    logic drive;   // load next mosi bit
    logic sample;  // capture miso this edge
    logic check;   // compare captured bit
    logic clrErr;  // clear per-pass error
  } ctrlStrb_t;
endpackage

// File: rtl/thrDacCtrl.sv
module thrDacCtrl
  import thrDacPkg::*;
#(
  parameter int NUM_DEV   = 8,
  parameter int NUM_CH    = 8,
  parameter int CLK_DIV   = 4,
  parameter int MAX_RETRY = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic passErr,
  output ctrlStrb_t strb,
  output logic [$clog2(NUM_DEV)-1:0] curSlot,
  output logic [$clog2(FRAME_W)-1:0] curBit,
  output logic [$clog2(NUM_DEV)-1:0] drvSlot,
  output logic [$clog2(FRAME_W)-1:0] drvBit,
  output logic [$clog2(NUM_CH+1)-1:0] passIdx,
  output logic csN,
  output logic sclk,
  output logic busy,
  output logic done,
  output logic error,
  output logic mismatch,
  output logic [$clog2(NUM_CH+1)-1:0] failPass
);
  localparam int SLOT_W = $clog2(NUM_DEV);
  localparam int BIT_W  = $clog2(FRAME_W);
  localparam int PASS_W = $clog2(NUM_CH+1);
  localparam int DIV_W  = $clog2(CLK_DIV);
  localparam int HALF   = CLK_DIV / 2;
  localparam int RTY_W  = $clog2(MAX_RETRY + 2);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_SHIFT, S_HOLD, S_GAP} state_t;
  state_t state;
  logic [DIV_W-1:0] divCnt;
  logic [RTY_W-1:0] retryCnt;
  logic lastBit, halfPt, fullPt;

  assign lastBit = (curSlot == SLOT_W'(NUM_DEV-1)) && (curBit == BIT_W'(FRAME_W-1));
  assign halfPt  = (divCnt == DIV_W'(HALF-1));
  assign fullPt  = (divCnt == DIV_W'(CLK_DIV-1));
  assign busy    = (state != S_IDLE);

  always_comb begin
    strb    = '0;
    drvSlot = curSlot;
    drvBit  = curBit;
    case (state)
      S_PREP: begin
        strb.drive  = 1'b1;
        strb.clrErr = 1'b1;
      end
      S_SHIFT: begin
        if (halfPt) begin
          strb.sample = 1'b1;
          strb.check  = (passIdx != '0);
        end
        if (fullPt && !lastBit) begin
          strb.drive = 1'b1;
          if (curBit == BIT_W'(FRAME_W-1)) begin
            drvBit  = '0;
            drvSlot = curSlot + SLOT_W'(1);
          end else begin
            drvBit = curBit + BIT_W'(1);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      divCnt   <= '0;
      curSlot  <= '0;
      curBit   <= '0;
      passIdx  <= '0;
      retryCnt <= '0;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      mismatch <= 1'b0;
      failPass <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done     <= 1'b0;
          error    <= 1'b0;
          mismatch <= 1'b0;
          retryCnt <= '0;
          passIdx  <= '0;
          state    <= S_PREP;
        end
        S_PREP: begin
          csN    <= 1'b0;
          divCnt <= '0;
          state  <= S_SHIFT;
        end
        S_SHIFT: begin
          divCnt <= divCnt + DIV_W'(1);
          if (halfPt) sclk <= 1'b1;
          if (fullPt) begin
            sclk   <= 1'b0;
            divCnt <= '0;
            if (lastBit) begin
              curSlot <= '0;
              curBit  <= '0;
              state   <= S_HOLD;
            end else begin
              curSlot <= drvSlot;
              curBit  <= drvBit;
            end
          end
        end
        S_HOLD: begin
          divCnt <= divCnt + DIV_W'(1);
          if (halfPt) begin
            csN    <= 1'b1;
            divCnt <= '0;
            state  <= S_GAP;
          end
        end
        S_GAP: begin
          divCnt <= divCnt + DIV_W'(1);
          if (fullPt) begin
            divCnt <= '0;
            if (passErr) begin
              mismatch <= 1'b1;
              failPass <= passIdx - PASS_W'(1);
              if (retryCnt < RTY_W'(MAX_RETRY)) begin
                retryCnt <= retryCnt + RTY_W'(1);
                passIdx  <= '0;
                state    <= S_PREP;
              end else begin
                error <= 1'b1;
                state <= S_IDLE;
              end
            end else if (passIdx == PASS_W'(NUM_CH)) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              passIdx <= passIdx + PASS_W'(1);
              state   <= S_PREP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thrDacDatapath.sv
module thrDacDatapath
  import thrDacPkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int NUM_CH  = 8,
  parameter int CODE_W  = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [$clog2(NUM_DEV*NUM_CH)-1:0] regAddr,
  input  logic [CODE_W-1:0] regWrData,
  input  logic busy,
  input  ctrlStrb_t strb,
  input  logic [$clog2(NUM_DEV)-1:0] curSlot,
  input  logic [$clog2(FRAME_W)-1:0] curBit,
  input  logic [$clog2(NUM_DEV)-1:0] drvSlot,
  input  logic [$clog2(FRAME_W)-1:0] drvBit,
  input  logic [$clog2(NUM_CH+1)-1:0] passIdx,
  input  logic miso,
  output logic mosi,
  output logic passErr
);
  localparam int SLOT_W  = $clog2(NUM_DEV);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int PASS_W  = $clog2(NUM_CH+1);
  localparam int RF_N    = NUM_DEV * NUM_CH;
  localparam int RF_AW   = $clog2(RF_N);
  localparam int PAD_W   = FRAME_W - CMD_W - ADDR_W - CODE_W;

  logic [CODE_W-1:0] codeMem [RF_N];
  logic [FRAME_W-1:0] txWord, expWord;
  logic [PASS_W-1:0] prevPass;
  logic txBit, expBit;

  // code store, host side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RF_N; i++) codeMem[i] <= '0;
    end else if (regWrEn && !busy) begin
      codeMem[regAddr] <= regWrData;
    end
  end

  function automatic logic [FRAME_W-1:0] frameFor(input logic [SLOT_W-1:0] slot,
                                                 input logic [PASS_W-1:0] pass);
    int dev;
    logic [RF_AW-1:0] idx;
    dev = NUM_DEV - 1 - int'(slot);
    idx = RF_AW'(dev * NUM_CH + ((int'(pass) < NUM_CH) ? int'(pass) : 0));
    if (int'(pass) < NUM_CH)
      frameFor = {CMD_WRUPD, ADDR_W'(pass), codeMem[idx], {PAD_W{1'b0}}};
    else
      frameFor = {CMD_NOP, {(FRAME_W-CMD_W){1'b0}}};
  endfunction

  assign prevPass = passIdx - PASS_W'(1);

  always_comb begin
    txWord  = frameFor(drvSlot, passIdx);
    expWord = frameFor(curSlot, prevPass);
    txBit   = txWord[BIT_W'(FRAME_W-1) - drvBit];
    expBit  = expWord[BIT_W'(FRAME_W-1) - curBit];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mosi    <= 1'b0;
      passErr <= 1'b0;
    end else begin
      if (strb.drive) mosi <= txBit;
      if (strb.clrErr) passErr <= 1'b0;
      else if (strb.sample && strb.check && (miso != expBit)) passErr <= 1'b1;
    end
  end
endmodule

// File: rtl/thrDacLoader.sv
module thrDacLoader
  import thrDacPkg::*;
#(
  parameter int NUM_DEV   = 8,
  parameter int NUM_CH    = 8,
  parameter int CODE_W    = 12,
  parameter int CLK_DIV   = 4,
  parameter int MAX_RETRY = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [$clog2(NUM_DEV*NUM_CH)-1:0] regAddr,
  input  logic [CODE_W-1:0] regWrData,
  input  logic start,
  output logic busy,
  output logic sclk,
  output logic csN,
  output logic mosi,
  input  logic miso,
  output logic done,
  output logic error,
  output logic mismatch,
  output logic [$clog2(NUM_CH+1)-1:0] failPass
);
  localparam int SLOT_W = $clog2(NUM_DEV);
  localparam int BIT_W  = $clog2(FRAME_W);
  localparam int PASS_W = $clog2(NUM_CH+1);

  ctrlStrb_t strb;
  logic [SLOT_W-1:0] curSlot, drvSlot;
  logic [BIT_W-1:0]  curBit, drvBit;
  logic [PASS_W-1:0] passIdx;
  logic passErr;

  thrDacCtrl #(.NUM_DEV(NUM_DEV), .NUM_CH(NUM_CH), .CLK_DIV(CLK_DIV), .MAX_RETRY(MAX_RETRY)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .passErr(passErr), .strb(strb),
    .curSlot(curSlot), .curBit(curBit), .drvSlot(drvSlot), .drvBit(drvBit),
    .passIdx(passIdx), .csN(csN), .sclk(sclk), .busy(busy), .done(done),
    .error(error), .mismatch(mismatch), .failPass(failPass)
  );

  thrDacDatapath #(.NUM_DEV(NUM_DEV), .NUM_CH(NUM_CH), .CODE_W(CODE_W)) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .busy(busy), .strb(strb), .curSlot(curSlot),
    .curBit(curBit), .drvSlot(drvSlot), .drvBit(drvBit), .passIdx(passIdx),
    .miso(miso), .mosi(mosi), .passErr(passErr)
  );
endmodule

// File: rtl/thrDacLoaderChk.sv
module thrDacLoaderChk #(
  parameter int NUM_CH = 8
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic sclk,
  input logic csN,
  input logic mosi,
  input logic done,
  input logic error,
  input logic mismatch,
  input logic [$clog2(NUM_CH+1)-1:0] failPass
);
  // R3
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN) !busy |-> csN);
  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sclk);
  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R8
  done_err_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0({done, error}));
  // R8
  finish_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || error));
  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!done && !error && !mismatch));
  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R7
  fail_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |-> (int'(failPass) < NUM_CH));
endmodule

bind thrDacLoader thrDacLoaderChk #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .sclk(sclk), .csN(csN),
  .mosi(mosi), .done(done), .error(error), .mismatch(mismatch), .failPass(failPass)
);

// File: tb/tb_thrDacLoader.sv
`timescale 1ns/1ps
module tb_thrDacLoader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [11:0] regWrData = '0;
  logic start = 1'b0;
  logic busy, sclk, csN, mosi, miso, done, error, mismatch;
  logic [3:0] failPass;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  thrDacLoader dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .start(start), .busy(busy), .sclk(sclk),
    .csN(csN), .mosi(mosi), .miso(miso), .done(done), .error(error),
    .mismatch(mismatch), .failPass(failPass)
  );

  // ---- behavioural chain of eight serial DACs ----
  logic [191:0] chain = '0;
  int bitCnt = 0;
  int winCnt = 0;
  logic [11:0] dacVal [8][8];
  logic [23:0] snapFirst = '0;
  int snapAt = -1;
  bit badLen = 0;
  bit mosiMoved = 0;
  time lastRise = 0;
  time sclkPer = 0;
  bit injectAll = 0;
  bit injectOn = 0;
  int injectAbs = -1;
  int expReg [8][8];

  assign miso = chain[191] ^ (injectAll | (injectOn && (winCnt == injectAbs)));

  always @(negedge csN) begin
    winCnt <= winCnt + 1;
  end

  always @(posedge sclk) begin
    if (!csN) begin
      chain <= {chain[190:0], mosi};
      if (bitCnt > 0) sclkPer <= $time - lastRise;
      lastRise <= $time;
      bitCnt <= bitCnt + 1;
    end
  end

  always @(posedge csN) begin
    if (winCnt > 0) begin
      if (bitCnt != 192) badLen <= 1;
      if (winCnt == snapAt) snapFirst <= chain[191:168];
      for (int d = 0; d < 8; d++) begin
        if (chain[d*24+20 +: 4] == 4'b0011 && chain[d*24+19] == 1'b0)
          dacVal[d][chain[d*24+16 +: 3]] <= chain[d*24+4 +: 12];
      end
    end
  end

  always @(negedge csN) bitCnt <= 0;

  always @(mosi) if (sclk && !csN) mosiMoved = 1;

  // ---- helpers ----
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input int d, input int c, input int v);
    @(negedge clk);
    regWrEn = 1; regAddr = 6'(d*8 + c); regWrData = 12'(v);
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic fillPattern(input int seed);
    for (int d = 0; d < 8; d++)
      for (int c = 0; c < 8; c++) begin
        expReg[d][c] = (d*291 + c*37 + seed) & 12'hFFF;
        writeReg(d, c, expReg[d][c]);
      end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic runLoad(output int wins);
    int base;
    base = winCnt;
    snapAt = base + 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    waitIdle();
    wins = winCnt - base;
  endtask

  task automatic checkDacs(input string tag);
    int bad = 0; int a = 0; int e = 0;
    for (int d = 0; d < 8; d++)
      for (int c = 0; c < 8; c++)
        if (int'(dacVal[d][c]) != expReg[d][c] && bad == 0) begin
          bad = 1; a = int'(dacVal[d][c]); e = expReg[d][c];
        end
    check(bad == 0, tag, a, e);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    check(csN == 1 && sclk == 0, "R10 link idle", {csN, sclk}, 2);
    check(!busy && !done && !error && !mismatch, "R10 flags", {busy, done, error, mismatch}, 0);
  endtask

  task automatic t_basic();
    int w;
    fillPattern(5);
    runLoad(w);
    check(w == 9, "R4 window count", w, 9);
    check(done && !error && !mismatch, "R8 clean done", {done, error, mismatch}, 4);
    checkDacs("R1 R4 codes latched");
    check(snapFirst == {4'b0011, 4'd0, 12'(expReg[7][0]), 4'd0}, "R2 R3 first frame",
          int'(snapFirst), {4'b0011, 4'd0, 12'(expReg[7][0]), 4'd0});
    check(chain[23:0] == 24'hF00000 && chain[191:168] == 24'hF00000, "R4 no-op pass",
          int'(chain[23:0]), 24'hF00000);
    check(!badLen, "R3 192 bits per window", int'(badLen), 0);
    check(!mosiMoved, "R5 mosi only while sclk low", int'(mosiMoved), 0);
    check(sclkPer == 32, "R5 sclk period", int'(sclkPer), 32);
  endtask

  task automatic t_extremes();
    int w;
    fillPattern(1000);
    expReg[0][7] = 12'hFFF; writeReg(0, 7, 12'hFFF);
    expReg[7][7] = 0;       writeReg(7, 7, 0);
    runLoad(w);
    check(done && w == 9, "R4 second pattern", w, 9);
    checkDacs("R2 extreme codes");
  endtask

  task automatic t_busyHold();
    int base; int w;
    base = winCnt;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (400) @(negedge clk);
    check(busy == 1, "R9 busy during load", int'(busy), 1);
    writeReg(0, 0, 12'h123);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    waitIdle();
    repeat (20) @(negedge clk);
    check(!busy && winCnt - base == 9, "R9 start ignored", winCnt - base, 9);
    runLoad(w);
    check(int'(dacVal[0][0]) == expReg[0][0], "R9 write ignored",
          int'(dacVal[0][0]), expReg[0][0]);
  endtask

  task automatic t_firstIgnored();
    int w;
    injectAbs = winCnt + 1; injectOn = 1;
    runLoad(w);
    injectOn = 0;
    check(done && !mismatch && w == 9, "R6 pass 0 return ignored", {done, mismatch}, 2);
  endtask

  task automatic t_singleFault();
    int w;
    injectAbs = winCnt + 4; injectOn = 1;
    runLoad(w);
    injectOn = 0;
    check(w == 13, "R7 retry restarts load", w, 13);
    check(done && !error && mismatch, "R7 sticky mismatch", {done, error, mismatch}, 5);
    check(failPass == 4'd2, "R7 failing pass index", int'(failPass), 2);
    checkDacs("R7 codes after retry");
  endtask

  task automatic t_persistent();
    int w;
    injectAll = 1;
    runLoad(w);
    injectAll = 0;
    check(w == 6, "R8 retry budget", w, 6);
    check(error && !done && mismatch, "R8 final error", {done, error, mismatch}, 3);
    check(failPass == 4'd0, "R7 failPass on pass 1", int'(failPass), 0);
    runLoad(w);
    check(done && !error && !mismatch, "R8 flags cleared on start", {done, error, mismatch}, 4);
  endtask

  task automatic t_sameCycle();
    int base;
    base = winCnt;
    @(negedge clk);
    regWrEn = 1; regAddr = 6'(3*8 + 5); regWrData = 12'hABC; start = 1;
    @(negedge clk);
    regWrEn = 0; start = 0;
    expReg[3][5] = 12'hABC;
    waitIdle();
    check(done && winCnt - base == 9, "R1 load with write", winCnt - base, 9);
    check(int'(dacVal[3][5]) == 12'hABC, "R1 same-cycle write used",
          int'(dacVal[3][5]), 12'hABC);
  endtask

  initial begin
    for (int d = 0; d < 8; d++)
      for (int c = 0; c < 8; c++) begin
        dacVal[d][c] = '0;
        expReg[d][c] = 0;
      end
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_extremes();
    t_busyHold();
    t_firstIgnored();
    t_singleFault();
    t_persistent();
    t_sameCycle();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule